// File: doc/BRIEF.md
# Full-Frame CCD Readout Clock Sequencer with On-Chip Binning

This block produces the digital control strobes that read out a full-frame CCD once an exposure has ended. A single start pulse captures the array size and the two binning factors. The sequencer then raises a shutter-close request and clears the serial register with one dump of full length. It then repeats one pattern for each super-row. It shifts one or more image rows down into the serial register, so that their charge adds together there. It then clocks the serial register toward the output node. Each super-pixel gets an output-node reset, a reference sample, a group of serial shifts and a signal sample, so the charge of the whole bin is converted once.

Each strobe lasts one clock. At most one strobe is active in any cycle, and from the first strobe to the end-of-frame pulse there is no idle cycle. Rows and columns left over when a dimension is not a multiple of its binning factor are thrown away. Leftover rows are never shifted. Leftover columns are clocked out of the serial register with no sampling. The analog clock drivers and the converter sit outside the block.

Top module: `ccd_readout_seq`

## Requirements
- R1: While reset is high and after it is released, every output is low until a start pulse is accepted.
- R2: Two cycles after an accepted start, the block issues exactly n_cols serial shifts in consecutive cycles with no reset or sample strobe, before any parallel shift. With n_cols of zero it issues none.
- R3: Each super-row begins with exactly vbin parallel shifts in consecutive cycles.
- R4: After the parallel shifts of a super-row, each super-pixel is the sequence node reset, reference sample, hbin serial shifts and signal sample, one strobe per cycle in that order.
- R5: A super-row holds floor(n_cols/hbin) super-pixels. The n_cols mod hbin leftover columns are then clocked out as serial shifts with no sampling, before the next super-row. Only floor(n_rows/vbin) super-rows are read, and leftover rows get no parallel shift.
- R6: shutter_close is high from the first strobe through the end-of-frame pulse. Inside that window exactly one of the six strobes (including frame_done) is high each cycle, and no strobe occurs while shutter_close is low.
- R7: pix_valid is high for one cycle, in the cycle right after each signal sample, and at no other time.
- R8: frame_done pulses for one cycle in the cycle after the last strobe of the frame. shutter_close falls in the following cycle.
- R9: A binning factor of 0 is treated as 1, and one above 8 is treated as 8.
- R10: The size and binning inputs are captured only at an accepted start. A start pulse or input change during a frame has no effect, and no second frame follows.
- R11: A frame with no complete super-row, or with zero columns, still ends with frame_done and releases the shutter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Starts a readout when the block is idle |
| n_rows | input | 13 | Row count, 0..4096 |
| n_cols | input | 13 | Column count, 0..4096 |
| vbin | input | 4 | Vertical binning factor |
| hbin | input | 4 | Horizontal binning factor |
| pshift | output | 1 | Parallel (row) shift strobe |
| sshift | output | 1 | Serial register shift strobe |
| node_rst | output | 1 | Output-node reset strobe |
| samp_ref | output | 1 | Reference-level sample strobe |
| samp_sig | output | 1 | Signal-level sample strobe |
| shutter_close | output | 1 | Request to keep the shutter closed |
| pix_valid | output | 1 | One super-pixel measurement is complete |
| frame_done | output | 1 | End-of-frame pulse |

## Verification
A miscounting row, column or run counter changes the length of one run of identical strobes. It shows up on the strobe stream at the first super-pixel, super-row or dump it affects, which can be only a few cycles into the frame. A wrong state transition breaks the fixed reset, reference, shift, signal order in the very next cycle, or leaves a cycle with no strobe while the shutter is closed. An edge-bin or clamping fault shows only in frames whose sizes are not multiples of the binning factors, or whose factors lie out of range, so those shapes are driven on purpose.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_FLUSH,
    ST_PAR,
    ST_RST,
    ST_REF,
    ST_XFER,
    ST_SIG,
    ST_DUMP,
    ST_DONE
  } seq_state_t;
endpackage

// File: rtl/ccd_seq_cfg.sv
// Captures array size and clamped binning factors on an accepted start.
module ccd_seq_cfg #(
  parameter int DIM_W   = 13,
  parameter int BIN_W   = 4,
  parameter int MAX_BIN = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             busy,
  input  logic [DIM_W-1:0] rows_in,
  input  logic [DIM_W-1:0] cols_in,
  input  logic [BIN_W-1:0] vbin_in,
  input  logic [BIN_W-1:0] hbin_in,
  output logic             go,
  output logic [DIM_W-1:0] rows_q,
  output logic [DIM_W-1:0] cols_q,
  output logic [BIN_W-1:0] vbin_q,
  output logic [BIN_W-1:0] hbin_q
);
  localparam logic [BIN_W-1:0] BIN_HI = BIN_W'(MAX_BIN);
  localparam logic [BIN_W-1:0] BIN_LO = BIN_W'(1);

  function automatic logic [BIN_W-1:0] clamp_bin(input logic [BIN_W-1:0] b);
    if (b == '0)         return BIN_LO;
    else if (b > BIN_HI) return BIN_HI;
    else                 return b;
  endfunction

  logic accept;
  assign accept = start && !busy && !go;

  always_ff @(posedge clk) begin
    if (rst) begin
      go     <= 1'b0;
      rows_q <= '0;
      cols_q <= '0;
      vbin_q <= BIN_LO;
      hbin_q <= BIN_LO;
    end else begin
      go <= accept;
      if (accept) begin
        rows_q <= rows_in;
        cols_q <= cols_in;
        vbin_q <= clamp_bin(vbin_in);
        hbin_q <= clamp_bin(hbin_in);
      end
    end
  end
endmodule

// File: rtl/ccd_seq_ctrl.sv
// Readout state machine: flush, parallel binning, CDS per super-pixel, edge dump.
module ccd_seq_ctrl
  import ccd_seq_pkg::*;
#(
  parameter int DIM_W = 13,
  parameter int BIN_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [DIM_W-1:0] rows_q,
  input  logic [DIM_W-1:0] cols_q,
  input  logic [BIN_W-1:0] vbin_q,
  input  logic [BIN_W-1:0] hbin_q,
  output seq_state_t       state,
  output logic             busy
);
  localparam int PAD = DIM_W - BIN_W;

  seq_state_t       st_n;
  logic [DIM_W-1:0] rows_left, rows_n;
  logic [DIM_W-1:0] cols_left, cols_n;
  logic [DIM_W-1:0] run, run_n;
  logic [DIM_W-1:0] vb_ext, hb_ext, rows_dec;

  assign vb_ext   = {{PAD{1'b0}}, vbin_q};
  assign hb_ext   = {{PAD{1'b0}}, hbin_q};
  assign rows_dec = rows_left - 1'b1;
  assign busy     = (state != ST_IDLE);

  always_comb begin
    st_n   = state;
    rows_n = rows_left;
    cols_n = cols_left;
    run_n  = run;
    case (state)
      ST_IDLE: if (go) begin
        rows_n = rows_q;
        cols_n = cols_q;
        if (cols_q != '0) begin
          st_n  = ST_FLUSH;
          run_n = cols_q;
        end else if (rows_q >= vb_ext) begin
          st_n  = ST_PAR;
          run_n = vb_ext;
        end else begin
          st_n = ST_DONE;
        end
      end
      ST_FLUSH, ST_DUMP: begin
        run_n = run - 1'b1;
        if (run == DIM_W'(1)) begin
          cols_n = cols_q;
          if (rows_left >= vb_ext) begin
            st_n  = ST_PAR;
            run_n = vb_ext;
          end else begin
            st_n = ST_DONE;
          end
        end
      end
      ST_PAR: begin
        rows_n = rows_dec;
        run_n  = run - 1'b1;
        if (run == DIM_W'(1)) begin
          if (cols_left >= hb_ext) begin
            st_n = ST_RST;
          end else if (cols_left != '0) begin
            st_n  = ST_DUMP;
            run_n = cols_left;
          end else if (rows_dec >= vb_ext) begin
            st_n  = ST_PAR;
            run_n = vb_ext;
          end else begin
            st_n = ST_DONE;
          end
        end
      end
      ST_RST: st_n = ST_REF;
      ST_REF: begin
        st_n  = ST_XFER;
        run_n = hb_ext;
      end
      ST_XFER: begin
        cols_n = cols_left - 1'b1;
        run_n  = run - 1'b1;
        if (run == DIM_W'(1)) st_n = ST_SIG;
      end
      ST_SIG: begin
        if (cols_left >= hb_ext) begin
          st_n = ST_RST;
        end else if (cols_left != '0) begin
          st_n  = ST_DUMP;
          run_n = cols_left;
        end else if (rows_left >= vb_ext) begin
          st_n   = ST_PAR;
          run_n  = vb_ext;
          cols_n = cols_q;
        end else begin
          st_n = ST_DONE;
        end
      end
      ST_DONE: st_n = ST_IDLE;
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      rows_left <= '0;
      cols_left <= '0;
      run       <= '0;
    end else begin
      state     <= st_n;
      rows_left <= rows_n;
      cols_left <= cols_n;
      run       <= run_n;
    end
  end
endmodule

// File: rtl/ccd_seq_strobe.sv
// Registered decode of the sequencer state onto the strobe outputs.
module ccd_seq_strobe
  import ccd_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  seq_state_t state,
  output logic       pshift,
  output logic       sshift,
  output logic       node_rst,
  output logic       samp_ref,
  output logic       samp_sig,
  output logic       shutter_close,
  output logic       pix_valid,
  output logic       frame_done
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pshift        <= 1'b0;
      sshift        <= 1'b0;
      node_rst      <= 1'b0;
      samp_ref      <= 1'b0;
      samp_sig      <= 1'b0;
      shutter_close <= 1'b0;
      pix_valid     <= 1'b0;
      frame_done    <= 1'b0;
    end else begin
      pshift        <= (state == ST_PAR);
      sshift        <= (state == ST_FLUSH) || (state == ST_XFER) || (state == ST_DUMP);
      node_rst      <= (state == ST_RST);
      samp_ref      <= (state == ST_REF);
      samp_sig      <= (state == ST_SIG);
      shutter_close <= (state != ST_IDLE);
      pix_valid     <= samp_sig;
      frame_done    <= (state == ST_DONE);
    end
  end
endmodule

// File: rtl/ccd_readout_seq.sv
module ccd_readout_seq
  import ccd_seq_pkg::*;
#(
  parameter int MAX_DIM = 4096,
  parameter int MAX_BIN = 8,
  parameter int DIM_W   = $clog2(MAX_DIM + 1),
  parameter int BIN_W   = $clog2(MAX_BIN + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [DIM_W-1:0] n_rows,
  input  logic [DIM_W-1:0] n_cols,
  input  logic [BIN_W-1:0] vbin,
  input  logic [BIN_W-1:0] hbin,
  output logic             pshift,
  output logic             sshift,
  output logic             node_rst,
  output logic             samp_ref,
  output logic             samp_sig,
  output logic             shutter_close,
  output logic             pix_valid,
  output logic             frame_done
);
  logic             go, busy;
  logic [DIM_W-1:0] rows_q, cols_q;
  logic [BIN_W-1:0] vbin_q, hbin_q;
  seq_state_t       state;

  ccd_seq_cfg #(.DIM_W(DIM_W), .BIN_W(BIN_W), .MAX_BIN(MAX_BIN)) cfg_i (
    .clk(clk), .rst(rst), .start(start), .busy(busy),
    .rows_in(n_rows), .cols_in(n_cols), .vbin_in(vbin), .hbin_in(hbin),
    .go(go), .rows_q(rows_q), .cols_q(cols_q), .vbin_q(vbin_q), .hbin_q(hbin_q)
  );

  ccd_seq_ctrl #(.DIM_W(DIM_W), .BIN_W(BIN_W)) ctrl_i (
    .clk(clk), .rst(rst), .go(go),
    .rows_q(rows_q), .cols_q(cols_q), .vbin_q(vbin_q), .hbin_q(hbin_q),
    .state(state), .busy(busy)
  );

  ccd_seq_strobe strobe_i (
    .clk(clk), .rst(rst), .state(state),
    .pshift(pshift), .sshift(sshift), .node_rst(node_rst),
    .samp_ref(samp_ref), .samp_sig(samp_sig), .shutter_close(shutter_close),
    .pix_valid(pix_valid), .frame_done(frame_done)
  );
endmodule

// File: rtl/ccd_seq_chk.sv
module ccd_seq_chk (
  input logic clk,
  input logic rst,
  input logic pshift,
  input logic sshift,
  input logic node_rst,
  input logic samp_ref,
  input logic samp_sig,
  input logic shutter_close,
  input logic pix_valid,
  input logic frame_done
);
  assert_one_strobe_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pshift, sshift, node_rst, samp_ref, samp_sig, frame_done}));

  assert_shutter_held_R6: assert property (@(posedge clk) disable iff (rst)
    (pshift || sshift || node_rst || samp_ref || samp_sig || frame_done) |-> shutter_close);

  assert_reset_then_ref_R4: assert property (@(posedge clk) disable iff (rst)
    node_rst |=> samp_ref);

  assert_ref_then_shift_R4: assert property (@(posedge clk) disable iff (rst)
    samp_ref |=> sshift);

  assert_shift_before_sig_R4: assert property (@(posedge clk) disable iff (rst)
    samp_sig |-> $past(sshift));

  assert_valid_after_sig_R7: assert property (@(posedge clk) disable iff (rst)
    samp_sig |=> pix_valid);

  assert_valid_in_frame_R7: assert property (@(posedge clk) disable iff (rst)
    pix_valid |-> shutter_close);

  assert_release_after_done_R8: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !shutter_close);
endmodule

bind ccd_readout_seq ccd_seq_chk chk_i (.*);

// File: tb/ccd_readout_seq_tb_top.sv
module ccd_readout_seq_tb_top;
  localparam int DW = 13;
  localparam int BW = 4;
  localparam logic [5:0] C_PAR  = 6'b000001;
  localparam logic [5:0] C_SER  = 6'b000010;
  localparam logic [5:0] C_RST  = 6'b000100;
  localparam logic [5:0] C_REF  = 6'b001000;
  localparam logic [5:0] C_SIG  = 6'b010000;
  localparam logic [5:0] C_DONE = 6'b100000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [DW-1:0] n_rows = '0;
  logic [DW-1:0] n_cols = '0;
  logic [BW-1:0] vbin = 4'd1;
  logic [BW-1:0] hbin = 4'd1;
  logic pshift, sshift, node_rst, samp_ref, samp_sig, shutter_close, pix_valid, frame_done;

  always #10 clk = ~clk;

  ccd_readout_seq dut_i (
    .clk(clk), .rst(rst), .start(start), .n_rows(n_rows), .n_cols(n_cols),
    .vbin(vbin), .hbin(hbin), .pshift(pshift), .sshift(sshift), .node_rst(node_rst),
    .samp_ref(samp_ref), .samp_sig(samp_sig), .shutter_close(shutter_close),
    .pix_valid(pix_valid), .frame_done(frame_done)
  );

  int checks = 0;
  int errors = 0;
  int exp_pix = 0;
  int got_pix = 0;
  int done_cnt = 0;
  logic prev_sig = 1'b0;
  logic [5:0] exp_q[$];
  string tag_q[$];

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int clamp_bin(input int b);
    if (b == 0) return 1;
    if (b > 8) return 8;
    return b;
  endfunction

  task automatic push(input logic [5:0] v, input string t, input string ovr);
    exp_q.push_back(v);
    tag_q.push_back((ovr == "") ? t : ovr);
  endtask

  // Driver: builds the expected strobe stream, then starts the frame.
  task automatic run_frame(input int r, input int c, input int vbr, input int hbr,
                           input bit poke, input string ovr);
    int vb, hb, rows, cols, target;
    vb = clamp_bin(vbr);
    hb = clamp_bin(hbr);
    for (int i = 0; i < c; i++) push(C_SER, "R2", ovr);
    rows = r;
    while (rows >= vb) begin
      for (int i = 0; i < vb; i++) push(C_PAR, "R3", ovr);
      rows -= vb;
      cols = c;
      while (cols >= hb) begin
        push(C_RST, "R4", ovr);
        push(C_REF, "R4", ovr);
        for (int i = 0; i < hb; i++) push(C_SER, "R4", ovr);
        push(C_SIG, "R4", ovr);
        exp_pix++;
        cols -= hb;
      end
      for (int i = 0; i < cols; i++) push(C_SER, "R5", ovr);
    end
    push(C_DONE, "R8", ovr);
    target = done_cnt + 1;
    @(negedge clk);
    n_rows = DW'(r);
    n_cols = DW'(c);
    vbin   = BW'(vbr);
    hbin   = BW'(hbr);
    start  = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (4) @(negedge clk);
      start  = 1'b1;
      n_rows = DW'(2);
      n_cols = DW'(3);
      vbin   = BW'(1);
      hbin   = BW'(1);
      @(negedge clk);
      start = 1'b0;
    end
    wait (done_cnt == target);
    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, (ovr == "") ? "R6" : ovr, "missing strobes", exp_q.size(), 0);
    chk(got_pix == exp_pix, "R7", "pix_valid count", got_pix, exp_pix);
    exp_q.delete();
    tag_q.delete();
    repeat (8) @(negedge clk);
    chk(shutter_close == 1'b0, "R10", "shutter after frame", shutter_close, 0);
  endtask

  // Monitor: pops the expected stream and compares each active cycle.
  always @(negedge clk) begin
    logic [5:0] v;
    logic [5:0] e;
    string t;
    if (!rst) begin
      v = {frame_done, samp_sig, samp_ref, node_rst, sshift, pshift};
      if (pix_valid) got_pix++;
      if (pix_valid || prev_sig)
        chk(pix_valid == prev_sig, "R7", "pix_valid timing", pix_valid, prev_sig);
      prev_sig = samp_sig;
      if (shutter_close) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R6", "unexpected active cycle", v, 0);
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(v == e, t, "strobe vector", v, e);
        end
      end else if (v != 6'b0) begin
        chk(1'b0, "R6", "strobe with shutter open", v, 0);
      end
      if (frame_done) done_cnt++;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk({pshift, sshift, node_rst, samp_ref, samp_sig, shutter_close, pix_valid, frame_done} == 8'b0,
        "R1", "outputs in reset", 1, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk({pshift, sshift, node_rst, samp_ref, samp_sig, shutter_close, pix_valid, frame_done} == 8'b0,
        "R1", "outputs idle after reset", 1, 0);
    run_frame(3, 4, 1, 1, 1'b0, "");
    run_frame(7, 10, 2, 3, 1'b0, "");
    run_frame(8, 8, 8, 8, 1'b0, "");
    run_frame(5, 6, 0, 12, 1'b0, "R9");
    run_frame(4, 0, 2, 2, 1'b0, "R11");
    run_frame(1, 5, 3, 1, 1'b0, "R11");
    run_frame(6, 6, 3, 2, 1'b1, "R10");
    run_frame(2, 3, 2, 1, 1'b0, "");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule